// File: doc/BRIEF.md
# Flag Offset Load Sequencer

This block keeps the two thresholds that drive a FIFO's programmable almost-empty and almost-full flags. Each threshold is stored as a low byte and a high byte, which makes four byte-wide offset registers in total. A single two-bit slot index selects one of them. Software-style loading happens through the FIFO's own write pins while a load pin is held LOW: every accepted write stores one byte and moves the index to the next slot. Readback works the same way through the read pins and moves the same index. Because the index is not cleared when the load pin goes HIGH, a later load session continues at the slot after the last one touched.

Load mode is chosen once, during reset. If the load pin is LOW while reset is applied, the block accepts offset accesses afterwards. If the pin is HIGH during reset, offset accesses are ignored for the whole session and the default thresholds stay in force. A comparator stage checks the FIFO occupancy against the two combined offsets on every clock and registers both flags.

The pins are plain level controls with no valid/ready handshake. The block accepts every write and read it is given and never applies back-pressure. A read result is held on the output until the next accepted read.

Top module: `flag_offset_seq`

## Requirements
- R1: While reset (`rst_n` LOW, asynchronous) is applied, the slot index returns to slot 0. Both offsets are set to `DEF_OFF` (7), `rd_data` is 0, `almost_empty_n` is 0, `almost_full_n` is 1 and `access_clash` is 0.
- R2: In load mode, a rising `clk` edge with `cfg_ld_n` LOW and `wr_en1_n` LOW stores `din` into the slot the index points at. It then advances the index by one. The slot numbering is: 0 = empty low byte, 1 = empty high byte, 2 = full low byte, 3 = full high byte.
- R3: An access to slot 3 moves the index back to slot 0.
- R4: Raising `cfg_ld_n` leaves the index unchanged, so the next load access continues at the following slot. An edge in load mode with no access also leaves the index unchanged.
- R5: In load mode, a rising edge with `cfg_ld_n` LOW and both `rd_en1_n` and `rd_en2_n` LOW copies the current slot (zero-padded to 8 bits) onto `rd_data` and advances the index. In every other cycle `rd_data` holds its value.
- R6: Load mode is on only if `cfg_ld_n` was LOW during reset. Otherwise, writes and reads with `cfg_ld_n` LOW change neither the offsets nor `rd_data`.
- R7: If a write and a read are requested on the same edge, only the write takes effect and the index advances once. `access_clash` is HIGH for the following cycle only.
- R8: `almost_empty_n` becomes LOW one clock after `level` is at most the empty offset, and HIGH otherwise. The empty offset is the slot 1 bits above the slot 0 byte.
- R9: `almost_full_n` becomes LOW one clock after `DEPTH - level` is at most the full offset, and HIGH otherwise. The full offset is the slot 3 bits above the slot 2 byte.
- R10: The high-byte slots keep only the low `log2(DEPTH)-8` bits of `din` (2 bits at `DEPTH` = 1024). The bits above them read back as zero.
- R11: Writes and reads with `cfg_ld_n` HIGH leave the offsets, the index and `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the write and read accesses |
| rst_n | input | 1 | Asynchronous reset, active LOW; `cfg_ld_n` is sampled while it is LOW |
| cfg_ld_n | input | 1 | Load pin: LOW selects offset access (load mode is chosen during reset) |
| wr_en1_n | input | 1 | Write enable, active LOW |
| rd_en1_n | input | 1 | First read enable, active LOW |
| rd_en2_n | input | 1 | Second read enable, active LOW |
| din | input | 8 | Byte written into the current slot |
| level | input | clog2(DEPTH+1) | FIFO occupancy in words, 0 to DEPTH |
| rd_data | output | 8 | Byte read back from the offset slots |
| almost_empty_n | output | 1 | Almost-empty flag, active LOW, registered |
| almost_full_n | output | 1 | Almost-full flag, active LOW, registered |
| access_clash | output | 1 | One-cycle pulse after a write and a read were requested together |

## Verification
The assertions rely on three conditions at the inputs. `level` never exceeds `DEPTH`. The clock keeps running while reset is LOW, so the load-mode choice is captured. `DEPTH` lies between 256 and 65536, so that each high byte holds between zero and eight bits. The stimulus keeps `level` within that range and holds `cfg_ld_n` steady for several clocks of every reset. It drives the enables only between clock edges, away from the edge that samples them. A behavioural model in the bench, built on plain integers, follows the index, the four slot values and the flag thresholds, and is compared with the outputs after every edge.

// File: rtl/fofs_pkg.sv
package fofs_pkg;

  typedef enum logic [1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } slot_e;

  function automatic slot_e slot_next(input slot_e s);
    logic [1:0] v;
    v = s;
    v = v + 2'd1;
    return slot_e'(v);
  endfunction

  function automatic logic slot_is_high(input slot_e s);
    return (s == SLOT_E_HI) || (s == SLOT_F_HI);
  endfunction

endpackage

// File: rtl/fofs_req_decode.sv
module fofs_req_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_ld_n,
  input  logic wr_en1_n,
  input  logic rd_en1_n,
  input  logic rd_en2_n,
  output logic prog_mode_o,
  output logic wr_req_o,
  output logic rd_req_o,
  output logic clash_o
);

  logic prog_q;
  logic clash_q;
  logic load_act;
  logic wr_try;
  logic rd_try;

  // Mode is captured while reset is held and then frozen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_q <= ~cfg_ld_n;
  end

  always_comb begin
    load_act = prog_q & ~cfg_ld_n;
    wr_try   = load_act & ~wr_en1_n;
    rd_try   = load_act & ~rd_en1_n & ~rd_en2_n;
  end

  // Write has priority over a read on the same edge
  assign wr_req_o    = wr_try;
  assign rd_req_o    = rd_try & ~wr_try;
  assign prog_mode_o = prog_q;
  assign clash_o     = clash_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clash_q <= 1'b0;
    else        clash_q <= wr_try & rd_try;
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(prog_q)); // R6

endmodule

// File: rtl/fofs_bank.sv
module fofs_bank
  import fofs_pkg::*;
#(
  parameter int OW      = 10,
  parameter int DEF_OFF = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [7:0]    din,
  output slot_e         cur_slot_o,
  output logic [7:0]    rd_byte_o,
  output logic [OW-1:0] empty_off_o,
  output logic [OW-1:0] full_off_o
);

  localparam int          HI_BITS = OW - 8;
  localparam logic [OW-1:0] DEF_V = OW'(DEF_OFF);

  slot_e      idx;
  logic [7:0] e_lo, f_lo;
  logic [7:0] e_hi_b, f_hi_b;

  // Shared rotating index for both access directions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx <= SLOT_E_LO;
    else if (wr_req || rd_req) idx <= slot_next(idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_lo <= DEF_V[7:0];
      f_lo <= DEF_V[7:0];
    end else if (wr_req) begin
      if (idx == SLOT_E_LO) e_lo <= din;
      if (idx == SLOT_F_LO) f_lo <= din;
    end
  end

  generate
    if (HI_BITS > 0) begin : g_hi
      logic [HI_BITS-1:0] e_hi, f_hi;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          e_hi <= DEF_V[OW-1:8];
          f_hi <= DEF_V[OW-1:8];
        end else if (wr_req) begin
          if (idx == SLOT_E_HI) e_hi <= din[HI_BITS-1:0];
          if (idx == SLOT_F_HI) f_hi <= din[HI_BITS-1:0];
        end
      end

      assign e_hi_b      = 8'(e_hi);
      assign f_hi_b      = 8'(f_hi);
      assign empty_off_o = {e_hi, e_lo};
      assign full_off_o  = {f_hi, f_lo};
    end else begin : g_nohi
      assign e_hi_b      = 8'h00;
      assign f_hi_b      = 8'h00;
      assign empty_off_o = e_lo[OW-1:0];
      assign full_off_o  = f_lo[OW-1:0];
    end
  endgenerate

  always_comb begin
    unique case (idx)
      SLOT_E_LO: rd_byte_o = e_lo;
      SLOT_E_HI: rd_byte_o = e_hi_b;
      SLOT_F_LO: rd_byte_o = f_lo;
      default:   rd_byte_o = f_hi_b;
    endcase
  end

  assign cur_slot_o = idx;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req || rd_req) |=> (idx == slot_next($past(idx)))); // R2
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_req || rd_req) && idx == SLOT_F_HI) |=> (idx == SLOT_E_LO)); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req || rd_req) |=> $stable(idx)); // R4
  AST_LO_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> ($stable(e_lo) && $stable(f_lo))); // R11

endmodule

// File: rtl/fofs_flags.sv
module fofs_flags #(
  parameter int DEPTH = 1024,
  parameter int OW    = 10,
  parameter int CW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level_i,
  input  logic [OW-1:0] empty_off_i,
  input  logic [OW-1:0] full_off_i,
  output logic          ae_n_o,
  output logic          af_n_o
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] free_w;
  logic [CW-1:0] e_thr;
  logic [CW-1:0] f_thr;

  always_comb begin
    free_w = DEPTH_C - level_i;
    e_thr  = CW'(empty_off_i);
    f_thr  = CW'(full_off_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_n_o <= 1'b0;
      af_n_o <= 1'b1;
    end else begin
      ae_n_o <= !(level_i <= e_thr);
      af_n_o <= !(free_w <= f_thr);
    end
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level_i <= DEPTH_C); // R9
  AST_EMPTY_IS_ALMOST: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == '0) |=> !ae_n_o); // R8
  AST_FULL_IS_ALMOST: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == DEPTH_C) |=> !af_n_o); // R9

endmodule

// File: rtl/flag_offset_seq.sv
module flag_offset_seq
  import fofs_pkg::*;
#(
  parameter  int DEPTH   = 1024,
  parameter  int DEF_OFF = 7,
  localparam int OW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ld_n,
  input  logic          wr_en1_n,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic [7:0]    din,
  input  logic [CW-1:0] level,
  output logic [7:0]    rd_data,
  output logic          almost_empty_n,
  output logic          almost_full_n,
  output logic          access_clash
);

  localparam int HI_BITS = OW - 8;

  logic          prog_mode;
  logic          wr_req;
  logic          rd_req;
  slot_e         cur_slot;
  logic [7:0]    rd_byte;
  logic [OW-1:0] empty_off;
  logic [OW-1:0] full_off;

  fofs_req_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ld_n    (cfg_ld_n),
    .wr_en1_n    (wr_en1_n),
    .rd_en1_n    (rd_en1_n),
    .rd_en2_n    (rd_en2_n),
    .prog_mode_o (prog_mode),
    .wr_req_o    (wr_req),
    .rd_req_o    (rd_req),
    .clash_o     (access_clash)
  );

  fofs_bank #(.OW(OW), .DEF_OFF(DEF_OFF)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (wr_req),
    .rd_req      (rd_req),
    .din         (din),
    .cur_slot_o  (cur_slot),
    .rd_byte_o   (rd_byte),
    .empty_off_o (empty_off),
    .full_off_o  (full_off)
  );

  fofs_flags #(.DEPTH(DEPTH), .OW(OW), .CW(CW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .level_i     (level),
    .empty_off_i (empty_off),
    .full_off_i  (full_off),
    .ae_n_o      (almost_empty_n),
    .af_n_o      (almost_full_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= 8'h00;
    else if (rd_req) rd_data <= rd_byte;
  end

  AST_NO_ACCESS_OUTSIDE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> $stable(rd_data)); // R6
  AST_CLASH_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    access_clash |-> $stable(rd_data)); // R7
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ld_n |=> $stable(rd_data)); // R11

  generate
    if (HI_BITS < 8) begin : g_pad_chk
      AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && slot_is_high(cur_slot)) |=> (rd_data[7:HI_BITS] == '0)); // R10
    end
  endgenerate

endmodule

// File: tb/flag_offset_seq_tb_top.sv
`timescale 1ns/1ps
module flag_offset_seq_tb_top;

  localparam int DEPTH   = 1024;
  localparam int HI_MASK = 3;   // 2 stored high-byte bits at this depth

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ld_n = 1'b1;
  logic        wr_en1_n = 1'b1;
  logic        rd_en1_n = 1'b1;
  logic        rd_en2_n = 1'b1;
  logic [7:0]  din = 8'h00;
  logic [10:0] level = '0;
  logic [7:0]  rd_data;
  logic        almost_empty_n;
  logic        almost_full_n;
  logic        access_clash;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural model state
  int m_reg[4];
  int m_idx;
  bit m_mode;
  int m_rd;
  bit m_ae_n, m_af_n, m_clash;

  always #2 clk = ~clk;

  flag_offset_seq dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_ld_n       (cfg_ld_n),
    .wr_en1_n       (wr_en1_n),
    .rd_en1_n       (rd_en1_n),
    .rd_en2_n       (rd_en2_n),
    .din            (din),
    .level          (level),
    .rd_data        (rd_data),
    .almost_empty_n (almost_empty_n),
    .almost_full_n  (almost_full_n),
    .access_clash   (access_clash)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "rd_data", int'(rd_data), m_rd);
    check(tag, "almost_empty_n", int'(almost_empty_n), int'(m_ae_n));
    check(tag, "almost_full_n", int'(almost_full_n), int'(m_af_n));
    check(tag, "access_clash", int'(access_clash), int'(m_clash));
  endtask

  // R1: reset state, with the load pin level selecting the mode (R6)
  task automatic do_reset(input logic ld);
    @(negedge clk);
    cfg_ld_n = ld; wr_en1_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    level = '0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_reg[0] = 7; m_reg[1] = 0; m_reg[2] = 7; m_reg[3] = 0;
    m_idx = 0; m_mode = !ld; m_rd = 0;
    m_ae_n = 1'b0; m_af_n = 1'b1; m_clash = 1'b0;
    #0.5;
    compare_all("R1");
  endtask

  task automatic step(input logic ld, input logic we, input logic r1, input logic r2,
                      input logic [7:0] d, input int lvl, input string tag);
    int eoff, foff;
    bit act, w, r;
    @(negedge clk);
    cfg_ld_n = ld; wr_en1_n = we; rd_en1_n = r1; rd_en2_n = r2;
    din = d; level = 11'(lvl);
    @(posedge clk);
    #1;
    eoff = m_reg[1] * 256 + m_reg[0];
    foff = m_reg[3] * 256 + m_reg[2];
    m_ae_n = !(lvl <= eoff);
    m_af_n = !((DEPTH - lvl) <= foff);
    act = m_mode && !ld;
    w = act && !we;
    r = act && !r1 && !r2;
    m_clash = w && r;
    if (w) begin
      m_reg[m_idx] = (m_idx % 2 == 1) ? (int'(d) & HI_MASK) : int'(d);
      m_idx = (m_idx + 1) % 4;
    end else if (r) begin
      m_rd = m_reg[m_idx];
      m_idx = (m_idx + 1) % 4;
    end
    compare_all(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    do_reset(1'b0);

    // R8 / R9 with default offsets; R11 idle load pin high
    step(1, 1, 1, 1, 8'h00, 0,    "R8");
    step(1, 1, 1, 1, 8'h00, 7,    "R8");
    step(1, 1, 1, 1, 8'h00, 8,    "R8");
    step(1, 1, 1, 1, 8'h00, 1016, "R9");
    step(1, 1, 1, 1, 8'h00, 1017, "R9");
    step(1, 1, 1, 1, 8'h00, 1024, "R9");

    // R2 load sequence, R10 masking, R3 wrap
    step(0, 0, 1, 1, 8'h20, 100, "R2");
    step(0, 0, 1, 1, 8'hFF, 100, "R10");
    step(0, 0, 1, 1, 8'h10, 100, "R2");
    step(0, 0, 1, 1, 8'h01, 100, "R2");
    step(0, 0, 1, 1, 8'h30, 100, "R3");

    // R11 accesses with load pin high; R4 index kept
    step(1, 0, 0, 0, 8'hAA, 100, "R11");
    step(1, 0, 1, 1, 8'h55, 100, "R11");
    step(0, 1, 1, 1, 8'h00, 100, "R4");
    step(0, 0, 1, 1, 8'h05, 100, "R4");

    // R5 readback and R10 zero padding
    step(0, 1, 0, 0, 8'h00, 100, "R5");
    step(0, 1, 0, 0, 8'h00, 100, "R10");
    step(0, 1, 0, 0, 8'h00, 100, "R5");
    step(0, 1, 0, 0, 8'h00, 100, "R10");
    step(0, 1, 0, 1, 8'h00, 100, "R5");
    step(0, 1, 1, 0, 8'h00, 100, "R5");

    // R7 clash: write wins, pulse one cycle
    step(0, 0, 0, 0, 8'h44, 100, "R7");
    step(0, 1, 1, 1, 8'h00, 100, "R7");
    step(0, 1, 0, 0, 8'h00, 100, "R5");

    // R8 / R9 with loaded offsets (empty 304, full 324)
    step(1, 1, 1, 1, 8'h00, 304, "R8");
    step(1, 1, 1, 1, 8'h00, 305, "R8");
    step(1, 1, 1, 1, 8'h00, 699, "R9");
    step(1, 1, 1, 1, 8'h00, 700, "R9");
    step(1, 1, 1, 1, 8'h00, 701, "R9");

    // R1 second reset returns index and defaults
    do_reset(1'b0);
    step(0, 1, 0, 0, 8'h00, 7, "R1");

    // R6 normal mode: load accesses ignored
    do_reset(1'b1);
    step(0, 0, 1, 1, 8'h99, 7, "R6");
    step(0, 0, 1, 1, 8'h99, 8, "R6");
    step(0, 1, 0, 0, 8'h00, 8, "R6");
    step(0, 0, 0, 0, 8'h12, 1017, "R6");
    step(1, 1, 1, 1, 8'h00, 1016, "R6");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule